// File: doc/BRIEF.md
# RF Field Wake-Up Controller

This block lets a near-field target chip wake up by itself when an external RF field shows up at its antenna. An always-on threshold register holds a 3-bit level code and a range-extend bit. Each cycle the sampled RF level (in millivolts) is compared against the threshold that the code selects. When the level rises above it, the block forces the chip's internal enable high even though the host has not asserted its own enable pin.

The wake-up is provisional. Once the oscillator reports stable, the block raises an interrupt carrying the field-change flag and shows oscillator-ok. When the first incoming frame starts, a second interrupt carries the RX-start flag. If the host drove its enable high at any point between those two interrupts, the chip stays up under host control. If it did not, the forced enable is dropped and the block waits for the field to go away before it will wake again. Whenever the field falls below threshold during the sequence or during the exchange, a field-change interrupt tells the host to abort.

Top module: `rf_wake_ctrl`

## Requirements
- R1: A threshold code (cfg bits 2:0) of 000 disables detection. For any RF level, `field_above_o` stays 0 and no wake-up occurs.
- R2: In the powered-down state with a nonzero code, a level strictly greater than the selected threshold drives `int_en_o` high one cycle later while `host_en_i` is low.
- R3: With cfg bit 3 clear, codes 1..7 select 480, 350, 250, 220, 190, 180, 170 mV. With bit 3 set, they select 1500, 700, 500, 450, 400, 320, 280 mV. A level equal to the threshold does not count as above it.
- R4: While waking, `osc_stable_i` high makes `osc_ok_o` go high one cycle later, together with a one-cycle `irq_o` pulse with `irq_field_o` set.
- R5: While armed, an `rx_start_i` pulse gives a one-cycle `irq_o` with `irq_rxs_o` set. If `host_en_i` was high in any armed cycle, including that one, the chip stays active and `int_en_o` then follows `host_en_i`.
- R6: If `rx_start_i` arrives while armed without host confirmation, the forced enable is cleared on the next cycle. The block does not wake again until the level has fallen to or below the threshold and risen above it once more.
- R7: The threshold register is cleared only by `aon_rst_n`. Core reset `rst_n` and a low `host_en_i` leave it unchanged.
- R8: `field_above_o` shows the registered comparator result in every state, including the active state under host control.
- R9: If the level drops to or below the threshold while waking, armed or active, `irq_o` pulses with `irq_field_o` on the next cycle and the block returns to powered down (`osc_ok_o` low).
- R10: `rx_start_i` has no effect while powered down or still waking: no interrupt and no change of `osc_ok_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Core asynchronous reset, active low |
| aon_rst_n | input | 1 | Always-on power-on reset, active low |
| cfg_we_i | input | 1 | Threshold register write strobe |
| cfg_wdata_i | input | 4 | Bit 3 range-extend, bits 2:0 threshold code |
| rf_level_i | input | LVL_W (11) | Sampled RF level in mV |
| osc_stable_i | input | 1 | Supply and oscillator stable |
| rx_start_i | input | 1 | Start of first incoming frame (pulse) |
| host_en_i | input | 1 | Host enable pin |
| int_en_o | output | 1 | Internal enable (host or forced) |
| field_above_o | output | 1 | Field above wake threshold status |
| osc_ok_o | output | 1 | Oscillator-ok status |
| irq_o | output | 1 | Interrupt pulse |
| irq_field_o | output | 1 | Interrupt cause: field change |
| irq_rxs_o | output | 1 | Interrupt cause: RX start |

## Verification
The hardest situation to reach is the lockout after an unconfirmed wake-up, because the field is still present and only the missing host action separates it from a normal active session. The stimulus holds the level above threshold through both interrupts while keeping the host enable low. It then checks that the enable stays off for several cycles. Finally it lowers and raises the level to show that wake-up is possible again. Threshold boundaries are driven at exactly the table value and one millivolt above it, in both ranges.

// File: rtl/rf_wake_pkg.sv
package rf_wake_pkg;
  localparam int CODE_W = 3;
  localparam int CFG_W  = CODE_W + 1;
  localparam int THR_W  = 11;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_WAKING = 3'd1,
    ST_ARMED  = 3'd2,
    ST_ACTIVE = 3'd3,
    ST_LOCK   = 3'd4
  } wake_st_e;

  // Threshold in mV for a range-extend bit and code; 0 means detection off.
  function automatic logic [THR_W-1:0] thr_mv(input logic ext, input logic [CODE_W-1:0] code);
    logic [THR_W-1:0] v;
    case ({ext, code})
      4'b0001: v = 11'd480;
      4'b0010: v = 11'd350;
      4'b0011: v = 11'd250;
      4'b0100: v = 11'd220;
      4'b0101: v = 11'd190;
      4'b0110: v = 11'd180;
      4'b0111: v = 11'd170;
      4'b1001: v = 11'd1500;
      4'b1010: v = 11'd700;
      4'b1011: v = 11'd500;
      4'b1100: v = 11'd450;
      4'b1101: v = 11'd400;
      4'b1110: v = 11'd320;
      4'b1111: v = 11'd280;
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/rf_wake_rst_sync.sv
module rf_wake_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/rf_wake_cfg.sv
module rf_wake_cfg
  import rf_wake_pkg::*;
(
  input  logic             clk,
  input  logic             aon_rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg
);
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = wdata;
  end

  always_ff @(posedge clk or negedge aon_rst_n) begin
    if (!aon_rst_n) cfg_q <= '0;
    else            cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/rf_wake_cmp.sv
module rf_wake_cmp
  import rf_wake_pkg::*;
#(
  parameter int LVL_W = 11
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic [LVL_W-1:0] level,
  output logic             hit
);
  localparam int CMP_W = (LVL_W > THR_W) ? LVL_W : THR_W;

  logic [CMP_W-1:0] lvl_ext;
  logic [CMP_W-1:0] thr_ext;
  logic             det_on;

  always_comb begin
    lvl_ext = CMP_W'(level);
    thr_ext = CMP_W'(thr_mv(cfg[CODE_W], cfg[CODE_W-1:0]));
    det_on  = |cfg[CODE_W-1:0];
    hit     = det_on && (lvl_ext > thr_ext);
  end
endmodule

// File: rtl/rf_wake_seq.sv
module rf_wake_seq
  import rf_wake_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic osc_stable,
  input  logic rx_start,
  input  logic host_en,
  output logic forced_en,
  output logic osc_ok,
  output logic field_above,
  output logic irq,
  output logic irq_field,
  output logic irq_rxs
);
  wake_st_e st_q, st_d;
  logic conf_q, conf_d;
  logic fa_q;
  logic irq_q, irq_d;
  logic irqf_q, irqf_d;
  logic irqr_q, irqr_d;

  always_comb begin
    st_d   = st_q;
    conf_d = conf_q;
    irqf_d = 1'b0;
    irqr_d = 1'b0;
    case (st_q)
      ST_OFF: begin
        conf_d = 1'b0;
        if (hit) st_d = ST_WAKING;
      end
      ST_WAKING: begin
        if (!hit) begin
          st_d   = ST_OFF;
          irqf_d = 1'b1;
        end else if (osc_stable) begin
          st_d   = ST_ARMED;
          irqf_d = 1'b1;
        end
      end
      ST_ARMED: begin
        if (!hit) begin
          st_d   = ST_OFF;
          irqf_d = 1'b1;
        end else if (rx_start) begin
          irqr_d = 1'b1;
          st_d   = (conf_q || host_en) ? ST_ACTIVE : ST_LOCK;
        end else if (host_en) begin
          conf_d = 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (!hit) begin
          st_d   = ST_OFF;
          irqf_d = 1'b1;
        end else if (!host_en) begin
          st_d = ST_LOCK;
        end
      end
      ST_LOCK: begin
        if (!hit) st_d = ST_OFF;
      end
      default: st_d = ST_OFF;
    endcase
    irq_d = irqf_d | irqr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      conf_q <= 1'b0;
      fa_q   <= 1'b0;
      irq_q  <= 1'b0;
      irqf_q <= 1'b0;
      irqr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      conf_q <= conf_d;
      fa_q   <= hit;
      irq_q  <= irq_d;
      irqf_q <= irqf_d;
      irqr_q <= irqr_d;
    end
  end

  assign forced_en   = (st_q == ST_WAKING) || (st_q == ST_ARMED);
  assign osc_ok      = (st_q == ST_ARMED) || (st_q == ST_ACTIVE);
  assign field_above = fa_q;
  assign irq         = irq_q;
  assign irq_field   = irqf_q;
  assign irq_rxs     = irqr_q;
endmodule

// File: rtl/rf_wake_ctrl.sv
module rf_wake_ctrl
  import rf_wake_pkg::*;
#(
  parameter int LVL_W   = 11,
  parameter int SYNC_ST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aon_rst_n,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic [LVL_W-1:0] rf_level_i,
  input  logic             osc_stable_i,
  input  logic             rx_start_i,
  input  logic             host_en_i,
  output logic             int_en_o,
  output logic             field_above_o,
  output logic             osc_ok_o,
  output logic             irq_o,
  output logic             irq_field_o,
  output logic             irq_rxs_o
);
  logic             core_rst_n;
  logic             aon_srst_n;
  logic [CFG_W-1:0] cfg_q;
  logic [CODE_W-1:0] cfg_code;
  logic             hit;
  logic             forced_en;

  rf_wake_rst_sync #(.STAGES(SYNC_ST)) u_rs_core (
    .clk(clk), .arst_n(rst_n), .srst_n(core_rst_n)
  );

  rf_wake_rst_sync #(.STAGES(SYNC_ST)) u_rs_aon (
    .clk(clk), .arst_n(aon_rst_n), .srst_n(aon_srst_n)
  );

  rf_wake_cfg u_cfg (
    .clk(clk), .aon_rst_n(aon_srst_n), .we(cfg_we_i), .wdata(cfg_wdata_i), .cfg(cfg_q)
  );

  assign cfg_code = cfg_q[CODE_W-1:0];

  rf_wake_cmp #(.LVL_W(LVL_W)) u_cmp (
    .cfg(cfg_q), .level(rf_level_i), .hit(hit)
  );

  rf_wake_seq u_seq (
    .clk(clk), .rst_n(core_rst_n), .hit(hit), .osc_stable(osc_stable_i),
    .rx_start(rx_start_i), .host_en(host_en_i), .forced_en(forced_en),
    .osc_ok(osc_ok_o), .field_above(field_above_o), .irq(irq_o),
    .irq_field(irq_field_o), .irq_rxs(irq_rxs_o)
  );

  assign int_en_o = host_en_i | forced_en;
endmodule

// File: rtl/rf_wake_chk.sv
module rf_wake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_en_i,
  input logic       int_en_o,
  input logic       field_above_o,
  input logic       osc_ok_o,
  input logic       irq_o,
  input logic       irq_field_o,
  input logic       irq_rxs_o,
  input logic [2:0] thr_code
);
  assert_detect_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_code == 3'd0) |=> !field_above_o);

  assert_forced_needs_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en_o && !host_en_i) |-> field_above_o);

  assert_osc_ok_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_ok_o) |-> (irq_o && irq_field_o));

  assert_rxs_when_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rxs_o |-> $past(osc_ok_o));

  assert_loss_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_field_o && !osc_ok_o) |-> !field_above_o);
endmodule

bind rf_wake_ctrl rf_wake_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_en_i(host_en_i), .int_en_o(int_en_o),
  .field_above_o(field_above_o), .osc_ok_o(osc_ok_o), .irq_o(irq_o),
  .irq_field_o(irq_field_o), .irq_rxs_o(irq_rxs_o), .thr_code(cfg_code)
);

// File: tb/sim_rf_wake_ctrl.sv
`timescale 1ns/1ps
module sim_rf_wake_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, aon_rst_n, cfg_we, osc_stable, rx_start, host_en;
  logic [3:0]  cfg_wdata;
  logic [10:0] level;
  logic        int_en, field_above, osc_ok, irq, irq_field, irq_rxs;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rf_wake_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .aon_rst_n(aon_rst_n), .cfg_we_i(cfg_we),
    .cfg_wdata_i(cfg_wdata), .rf_level_i(level), .osc_stable_i(osc_stable),
    .rx_start_i(rx_start), .host_en_i(host_en), .int_en_o(int_en),
    .field_above_o(field_above), .osc_ok_o(osc_ok), .irq_o(irq),
    .irq_field_o(irq_field), .irq_rxs_o(irq_rxs)
  );

  function automatic int exp_thr(input bit ext, input int code);
    int nrm [8] = '{0, 480, 350, 250, 220, 190, 180, 170};
    int big [8] = '{0, 1500, 700, 500, 450, 400, 320, 280};
    return ext ? big[code] : nrm[code];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input bit ext, input int code);
    cfg_we = 1'b1; cfg_wdata = {ext, 3'(code)};
    step();
    cfg_we = 1'b0;
  endtask

  task automatic quiesce();
    level = '0; host_en = 0; osc_stable = 0; rx_start = 0;
    step(3);
  endtask

  task automatic wake_and_arm(input int lvl);
    level = 11'(lvl); step();
    chk("R2 forced enable", int_en, 1);
    osc_stable = 1'b1; step();
    osc_stable = 1'b0;
    chk("R4 irq", irq, 1); chk("R4 field flag", irq_field, 1); chk("R4 osc_ok", osc_ok, 1);
  endtask

  task automatic t_reset();
    chk("reset int_en", int_en, 0); chk("reset irq", irq, 0);
    chk("reset field_above", field_above, 0); chk("reset osc_ok", osc_ok, 0);
  endtask

  task automatic t_disabled();
    write_cfg(1'b0, 0);
    level = 11'd2047; step();
    chk("R1 field_above", field_above, 0); chk("R1 int_en", int_en, 0);
    step(2);
    chk("R1 still off", int_en, 0);
    quiesce();
  endtask

  task automatic t_thresholds();
    for (int e = 0; e < 2; e++) begin
      for (int c = 1; c < 8; c++) begin
        write_cfg(e[0], c);
        level = 11'(exp_thr(e[0], c)); step();
        chk($sformatf("R3 equal e%0d c%0d", e, c), field_above, 0);
        chk("R3 equal no wake", int_en, 0);
        level = 11'(exp_thr(e[0], c) + 1); step();
        chk($sformatf("R3 above e%0d c%0d", e, c), field_above, 1);
        chk("R2 wake above", int_en, 1);
        quiesce();
      end
    end
  endtask

  task automatic t_confirmed();
    write_cfg(1'b0, 3);
    level = 11'd300; step();
    chk("R2 int_en host low", int_en, 1); chk("R2 osc_ok not yet", osc_ok, 0);
    rx_start = 1'b1; step(); rx_start = 1'b0;
    chk("R10 rx_start while waking irq", irq, 0); chk("R10 osc_ok", osc_ok, 0);
    osc_stable = 1'b1; step(); osc_stable = 1'b0;
    chk("R4 irq", irq, 1); chk("R4 field flag", irq_field, 1); chk("R4 osc_ok", osc_ok, 1);
    step();
    chk("R4 irq one cycle", irq, 0);
    host_en = 1'b1; step();
    rx_start = 1'b1; step(); rx_start = 1'b0;
    chk("R5 irq", irq, 1); chk("R5 rxs flag", irq_rxs, 1); chk("R5 field flag clear", irq_field, 0);
    step(3);
    chk("R5 stays on", int_en, 1); chk("R8 field_above in active", field_above, 1);
    chk("R5 osc_ok active", osc_ok, 1);
    level = 11'd100; step();
    chk("R9 irq active loss", irq, 1); chk("R9 field flag", irq_field, 1);
    chk("R9 osc_ok low", osc_ok, 0); chk("R8 field_above dropped", field_above, 0);
    quiesce();
  endtask

  task automatic t_unconfirmed();
    write_cfg(1'b1, 2);
    wake_and_arm(800);
    rx_start = 1'b1; step(); rx_start = 1'b0;
    chk("R6 second irq", irq_rxs, 1); chk("R6 forced cleared", int_en, 0);
    step(3);
    chk("R6 lockout int_en", int_en, 0); chk("R6 lockout irq", irq, 0);
    chk("R8 field_above in lockout", field_above, 1);
    level = 11'd600; step();
    chk("R6 drop no irq", irq, 0);
    level = 11'd800; step();
    chk("R6 rewake", int_en, 1);
    quiesce();
  endtask

  task automatic t_field_loss();
    write_cfg(1'b0, 1);
    wake_and_arm(500);
    level = 11'd480; step();
    chk("R9 irq armed loss", irq, 1); chk("R9 field flag", irq_field, 1);
    chk("R9 int_en off", int_en, 0); chk("R9 osc_ok off", osc_ok, 0);
    step();
    rx_start = 1'b1; step(); rx_start = 1'b0;
    chk("R10 rx_start while off", irq, 0);
    quiesce();
  endtask

  task automatic t_retention();
    write_cfg(1'b1, 1);
    rst_n = 1'b0; step(3); rst_n = 1'b1; step(3);
    t_reset();
    level = 11'd1400; step();
    chk("R7 below after core reset", field_above, 0);
    level = 11'd1600; step();
    chk("R7 kept over core reset", field_above, 1); chk("R7 wake", int_en, 1);
    quiesce();
    rst_n = 1'b0; aon_rst_n = 1'b0; step(3); rst_n = 1'b1; aon_rst_n = 1'b1; step(3);
    level = 11'd1600; step();
    chk("R7 cleared by aon reset", field_above, 0);
    quiesce();
  endtask

  initial begin
    rst_n = 0; aon_rst_n = 0; cfg_we = 0; cfg_wdata = '0; level = '0;
    osc_stable = 0; rx_start = 0; host_en = 0;
    step(3);
    rst_n = 1; aon_rst_n = 1;
    step(3);
    t_reset();
    t_disabled();
    t_thresholds();
    t_confirmed();
    t_unconfirmed();
    t_field_loss();
    t_retention();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule